// File: doc/BRIEF.md
# Scoreboard-Gated Warp Issue Scheduler

This block is a single issue slot of a compute sub-partition. It watches a set of resident warps, by default twelve. Each cycle it picks at most one warp whose next instruction may go, and reports that warp's id.

No register dependencies are checked in hardware. Eligibility comes only from a control word that the compiler attached to each instruction. That word carries four things:
- a static stall count;
- a yield hint;
- up to two indices of per-warp scoreboard barriers that the instruction arms;
- a mask of barriers that must be clear before the instruction may issue.

Variable-latency units return release events of the form (warp, barrier). Each barrier counts its outstanding setters, so several in-flight instructions can share one barrier.

Selection is greedy with round-robin fallback. The search starts at the warp that issued last and walks upward with wraparound, so a warp keeps the slot while it stays eligible. When that warp stalls, waits or yields, the slot moves on to the next eligible warp.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one warp is issued per cycle, and only a warp whose ready input is high. When no warp is ready, `issue_valid_o` stays low.
- R2: Control word fields per warp:
  - bits 3:0 stall count;
  - bit 4 yield;
  - bits 7:5 first set-barrier index;
  - bits 10:8 second set-barrier index;
  - bits 16:11 wait mask, where bit 11+b names barrier b;
  - bits 20:17 reuse flags.
- R3: A warp issued with stall count s may not issue again for max(s,1) cycles. A lone ready warp with s=4 issues, idles three cycles, then issues again. A lone warp with s=0 or s=1 issues every cycle.
- R4: Each set-barrier index 0 to 5 adds one to that barrier's pending count for the issuing warp. If both indices name the same barrier, the count rises by two. Index values 6 and 7 arm nothing.
- R5: A warp whose wait mask names a barrier that is pending for that warp is not eligible. Other warps keep issuing. Pending barriers that the mask does not name have no effect.
- R6: A release (warp, barrier) lowers that count by one. The barrier clears only after as many releases as sets. The waiting warp may issue from the cycle after the clearing release.
- R7: `rel_err_o` is high in the same cycle as a release that names a barrier with a zero count, a barrier index above 5, or a warp id out of range. Such a release changes no state. A release to a barrier of another warp does not clear this warp's barrier.
- R8: The search for an eligible warp starts at the last issued warp, inclusive, and proceeds upward with wraparound. After reset it starts at warp 0.
- R9: In the cycle after a warp issues with yield set, that warp is chosen only if no other warp is eligible.
- R10: The reuse flags have no effect on issue order or timing.
- R11: After reset all stall counts and barrier counts are zero and no yield is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready_i | input | NUM_WARPS | Warp has a decoded instruction waiting |
| warp_ctrl_i | input | NUM_WARPS*21 | Control word of each warp's waiting instruction, warp w at bits 21w+20:21w |
| rel_valid_i | input | 1 | Barrier release event |
| rel_warp_i | input | WID_W | Warp of the release |
| rel_bar_i | input | 3 | Barrier index of the release |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_warp_o | output | WID_W | Id of the issuing warp |
| rel_err_o | output | 1 | Release hit an empty or invalid barrier |

## Verification
The bench runs several patterns, and each one separates behaviours that a simpler patterns would not:
- **All warps ready with no stall.** This separates the greedy search from plain round-robin.
- **All warps ready with a stall of two.** This shows the handoff walking upward through every warp and wrapping back to warp 0.
- **One warp with a long stall and reuse flags set.** This exposes the exact idle gap and shows the reuse bits do nothing.
- **Barrier sequence.** One warp arms the same barrier twice, then waits on an unrelated barrier, then on the armed one, while a stalled neighbour fills the gaps. The releases are interleaved with a wrong-warp release and a release to an empty barrier. This tells apart counting, per-warp isolation, the release latency and error flagging.
- **Two warps where one yields.** This shows the yield moving the slot to the other warp, and also the lone-yielder case where the hint must not block issue.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int NUM_BARS  = 6;
  localparam int BAR_IDX_W = 3;
  localparam int STALL_W   = 4;
  localparam int REUSE_W   = 4;

  typedef struct packed {
    logic [REUSE_W-1:0]   reuse;
    logic [NUM_BARS-1:0]  wait_mask;
    logic [BAR_IDX_W-1:0] rd_bar;
    logic [BAR_IDX_W-1:0] wr_bar;
    logic                 yield;
    logic [STALL_W-1:0]   stall;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int WAIT_LSB = STALL_W + 1 + 2 * BAR_IDX_W;
endpackage

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!gnt_valid && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/ws_stall_timer.sv
module ws_stall_timer
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int WID_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [WID_W-1:0]     iss_warp,
  input  logic [STALL_W-1:0]   iss_stall,
  output logic [NUM_WARPS-1:0] stall_done
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [STALL_W-1:0] cnt_q, cnt_d;
    logic               cnt_en, hit;

    assign hit = iss_valid && (iss_warp == WID_W'(w));

    always_comb begin
      cnt_en = hit || (cnt_q != '0);
      cnt_d  = cnt_q;
      if (hit)                cnt_d = (iss_stall == '0) ? '0 : iss_stall - 1'b1;
      else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign stall_done[w] = (cnt_q == '0);
  end
endmodule

// File: rtl/ws_bar_bank.sv
module ws_bar_bank
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int WID_W     = 4,
  parameter int CNT_W     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                set_valid,
  input  logic [WID_W-1:0]                    set_warp,
  input  logic [BAR_IDX_W-1:0]                set_bar_a,
  input  logic [BAR_IDX_W-1:0]                set_bar_b,
  input  logic                                rel_valid,
  input  logic [WID_W-1:0]                    rel_warp,
  input  logic [BAR_IDX_W-1:0]                rel_bar,
  output logic [NUM_WARPS-1:0][NUM_BARS-1:0]  pending,
  output logic                                rel_err
);
  logic rel_ok;

  always_comb begin
    rel_ok = 1'b0;
    if (rel_valid && int'(rel_warp) < NUM_WARPS && int'(rel_bar) < NUM_BARS)
      rel_ok = pending[rel_warp][rel_bar];
  end

  assign rel_err = rel_valid && !rel_ok;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic [1:0]       add;
      logic             sub, cnt_en, set_hit;

      assign set_hit = set_valid && (set_warp == WID_W'(w));

      always_comb begin
        add    = 2'(set_hit && (set_bar_a == BAR_IDX_W'(b)))
               + 2'(set_hit && (set_bar_b == BAR_IDX_W'(b)));
        sub    = rel_ok && (rel_warp == WID_W'(w)) && (rel_bar == BAR_IDX_W'(b));
        cnt_en = (add != 2'd0) || sub;
        cnt_d  = cnt_q + CNT_W'(add) - CNT_W'(sub);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign pending[w][b] = (cnt_q != '0);
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int CNT_W     = 4,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WARPS-1:0]          warp_ready_i,
  input  logic [NUM_WARPS*CTRL_W-1:0]   warp_ctrl_i,
  input  logic                          rel_valid_i,
  input  logic [WID_W-1:0]              rel_warp_i,
  input  logic [BAR_IDX_W-1:0]          rel_bar_i,
  output logic                          issue_valid_o,
  output logic [WID_W-1:0]              issue_warp_o,
  output logic                          rel_err_o
);
  logic [NUM_WARPS-1:0][NUM_BARS-1:0] pending;
  logic [NUM_WARPS-1:0]               stall_done, elig, yld_q, yld_d;
  logic [WID_W-1:0]                   last_q, last_d;
  logic                               hi_v, lo_v;
  logic [WID_W-1:0]                   hi_idx, lo_idx;
  ctrl_t                              iss_ctrl;
  logic                               unused_ctrl_bits;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    logic [NUM_BARS-1:0] wmask;
    assign wmask   = warp_ctrl_i[w*CTRL_W + WAIT_LSB +: NUM_BARS];
    assign elig[w] = warp_ready_i[w] && stall_done[w] && ((wmask & pending[w]) == '0);
  end

  ws_rr_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick_hi (
    .req(elig & ~yld_q), .start(last_q), .gnt_valid(hi_v), .gnt_idx(hi_idx));
  ws_rr_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick_lo (
    .req(elig), .start(last_q), .gnt_valid(lo_v), .gnt_idx(lo_idx));

  assign issue_valid_o    = hi_v || lo_v;
  assign issue_warp_o     = hi_v ? hi_idx : lo_idx;
  assign iss_ctrl         = warp_ctrl_i[int'(issue_warp_o)*CTRL_W +: CTRL_W];
  assign unused_ctrl_bits = ^{iss_ctrl.reuse, iss_ctrl.wait_mask};

  ws_stall_timer #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_timer (
    .clk, .rst_n,
    .iss_valid(issue_valid_o), .iss_warp(issue_warp_o), .iss_stall(iss_ctrl.stall),
    .stall_done(stall_done));

  ws_bar_bank #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .CNT_W(CNT_W)) u_bars (
    .clk, .rst_n,
    .set_valid(issue_valid_o), .set_warp(issue_warp_o),
    .set_bar_a(iss_ctrl.wr_bar), .set_bar_b(iss_ctrl.rd_bar),
    .rel_valid(rel_valid_i), .rel_warp(rel_warp_i), .rel_bar(rel_bar_i),
    .pending(pending), .rel_err(rel_err_o));

  always_comb begin
    last_d = issue_valid_o ? issue_warp_o : last_q;
    for (int w = 0; w < NUM_WARPS; w++)
      yld_d[w] = issue_valid_o && (issue_warp_o == WID_W'(w)) && iss_ctrl.yield;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      yld_q  <= '0;
    end else begin
      if (issue_valid_o) last_q <= last_d;
      yld_q <= yld_d;
    end
  end
endmodule

// File: rtl/ws_sched_chk.sv
module ws_sched_chk
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = 12,
  parameter int WID_W     = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_WARPS-1:0]                warp_ready_i,
  input logic [NUM_WARPS*CTRL_W-1:0]         warp_ctrl_i,
  input logic                                rel_valid_i,
  input logic [WID_W-1:0]                    rel_warp_i,
  input logic [BAR_IDX_W-1:0]                rel_bar_i,
  input logic                                issue_valid_o,
  input logic [WID_W-1:0]                    issue_warp_o,
  input logic                                rel_err_o,
  input logic [NUM_WARPS-1:0][NUM_BARS-1:0]  pending
);
  ctrl_t c_iss;
  logic  rel_live;

  assign c_iss = warp_ctrl_i[int'(issue_warp_o)*CTRL_W +: CTRL_W];

  always_comb begin
    rel_live = 1'b0;
    if (rel_valid_i && int'(rel_warp_i) < NUM_WARPS && int'(rel_bar_i) < NUM_BARS)
      rel_live = pending[rel_warp_i][rel_bar_i];
  end

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (int'(issue_warp_o) < NUM_WARPS) && warp_ready_i[issue_warp_o]); // R1

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_ready_i == '0) |-> !issue_valid_o); // R1

  AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> ((c_iss.wait_mask & pending[issue_warp_o]) == '0)); // R5

  AST_STALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && c_iss.stall > 4'd1) |=>
      !(issue_valid_o && issue_warp_o == $past(issue_warp_o))); // R3

  AST_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_live |-> !rel_err_o); // R7

  AST_ERR_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid_i && !rel_live) |-> rel_err_o); // R7
endmodule

bind warp_issue_sched ws_sched_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_ready_i(warp_ready_i), .warp_ctrl_i(warp_ctrl_i),
  .rel_valid_i(rel_valid_i), .rel_warp_i(rel_warp_i), .rel_bar_i(rel_bar_i),
  .issue_valid_o(issue_valid_o), .issue_warp_o(issue_warp_o), .rel_err_o(rel_err_o),
  .pending(pending));

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
  localparam int CLK_P = 10;
  localparam int NW    = 12;
  localparam int CW    = 21;
  localparam int WD    = 20000;

  typedef struct {
    int    warp;
    string req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NW-1:0]     ready;
  logic [NW*CW-1:0]  ctrl;
  logic              rel_v;
  logic [3:0]        rel_w;
  logic [2:0]        rel_b;
  logic              iss_v;
  logic [3:0]        iss_w;
  logic              rel_err;

  int   n_chk = 0, n_fail = 0;
  bit   done  = 0;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW)) dut (
    .clk(clk), .rst_n(rst_n), .warp_ready_i(ready), .warp_ctrl_i(ctrl),
    .rel_valid_i(rel_v), .rel_warp_i(rel_w), .rel_bar_i(rel_b),
    .issue_valid_o(iss_v), .issue_warp_o(iss_w), .rel_err_o(rel_err));

  // R2 encoding: {reuse[20:17], wait[16:11], bar_b[10:8], bar_a[7:5], yield[4], stall[3:0]}
  function automatic logic [CW-1:0] mk(int st, bit y, int ba, int bb, logic [5:0] wm, logic [3:0] ru);
    return {ru, wm, 3'(bb), 3'(ba), y, 4'(st)};
  endfunction

  task automatic set_ctrl(int w, logic [CW-1:0] v);
    ctrl[w*CW +: CW] = v;
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step(int w, string req);
    exp_t e;
    e.warp = w; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic step_err(int w, string req, bit err_exp);
    exp_t e;
    e.warp = w; e.req = req;
    exp_q.push_back(e);
    #3;
    check(rel_err == err_exp, "R7", "rel_err", int'(rel_err), int'(err_exp));
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ready = '0;
    rel_v = 1'b0; rel_w = '0; rel_b = '0;
    for (int w = 0; w < NW; w++) set_ctrl(w, mk(0, 0, 7, 7, 6'd0, 4'd0));
    @(negedge clk);
    #3;
    check(iss_v == 1'b0, "R11", "issue during reset", int'(iss_v), 0);
    check(rel_err == 1'b0, "R11", "error during reset", int'(rel_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compare the scoreboard against the issue port once per cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.warp < 0)
          check(iss_v == 1'b0, e.req, "idle cycle issue_valid", int'(iss_v), 0);
        else
          check(iss_v && int'(iss_w) == e.warp, e.req, "issued warp",
                iss_v ? int'(iss_w) : -1, e.warp);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    ready = '0; ctrl = '0; rel_v = 1'b0; rel_w = '0; rel_b = '0; rst_n = 1'b0;
    @(negedge clk);

    // greedy search from warp 0 (R8, R11)
    do_reset();
    ready = '1;
    step(0, "R11"); step(0, "R8"); step(0, "R8");
    ready[0] = 1'b0;
    step(1, "R8");

    // stall 2 on all warps walks the slot upward and wraps (R8, R3)
    do_reset();
    ready = '1;
    for (int w = 0; w < NW; w++) set_ctrl(w, mk(2, 0, 7, 7, 6'd0, 4'd0));
    for (int w = 0; w < NW; w++) step(w, "R8");
    step(0, "R3");

    // lone warp, stall 4, reuse flags set (R3, R10)
    do_reset();
    set_ctrl(2, mk(4, 0, 7, 7, 6'd0, 4'hF));
    ready[2] = 1'b1;
    step(2, "R10"); step(-1, "R3"); step(-1, "R3"); step(-1, "R3"); step(2, "R3");
    ready[2] = 1'b0;
    step(-1, "R1");
    set_ctrl(5, mk(1, 0, 7, 7, 6'd0, 4'd0));
    ready[5] = 1'b1;
    step(5, "R3"); step(5, "R3");

    // barriers: double set, unrelated wait, blocking wait, releases (R4 R5 R6 R7)
    do_reset();
    set_ctrl(0, mk(0, 0, 2, 2, 6'd0, 4'd0));
    ready[0] = 1'b1;
    step(0, "R4");
    set_ctrl(0, mk(0, 0, 7, 7, 6'b000010, 4'd0));
    step(0, "R5");
    set_ctrl(0, mk(0, 0, 7, 7, 6'b000100, 4'd0));
    set_ctrl(3, mk(2, 0, 7, 7, 6'd0, 4'd0));
    ready[3] = 1'b1;
    step(3, "R5");
    rel_v = 1'b1; rel_w = 4'd1; rel_b = 3'd2;
    step_err(-1, "R7", 1'b1);
    rel_v = 1'b0;
    step(3, "R4");
    rel_v = 1'b1; rel_w = 4'd0; rel_b = 3'd2;
    step_err(-1, "R6", 1'b0);
    rel_v = 1'b0;
    step(3, "R6");
    rel_v = 1'b1;
    step_err(-1, "R6", 1'b0);
    rel_v = 1'b0;
    step(3, "R8");
    step(0, "R6");
    rel_v = 1'b1;
    step_err(0, "R7", 1'b1);
    rel_v = 1'b0;
    rel_b = 3'd6;
    rel_v = 1'b1;
    step_err(0, "R7", 1'b1);
    rel_v = 1'b0;

    // yield hands the slot over, lone yielder still issues (R9)
    do_reset();
    set_ctrl(3, mk(0, 1, 7, 7, 6'd0, 4'd0));
    ready[3] = 1'b1; ready[7] = 1'b1;
    step(3, "R9"); step(7, "R9"); step(7, "R9"); step(7, "R9");
    ready[7] = 1'b0;
    step(3, "R9"); step(3, "R9");
    ready = '0;
    step(-1, "R1");

    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule